// File: doc/BRIEF.md
# Staggered Four-Source IQ Output Merger

This block gathers complex samples from four identical processing channels that run side by side and finish at staggered times, and places them on one shared output bus. Each channel owns a data bus and a data-valid strobe. In normal operation the channels take turns in a fixed cyclic order. Each turn is a two-cycle burst: the in-phase (I) word comes first and the quadrature (Q) word follows. Six idle cycles then pass before the same channel bursts again, so one full rotation lasts eight cycles.

Each channel has a private input latch that loads only in cycles where that channel's strobe is high. A priority pick then chooses the latched word that goes to the shared output register. That register loads only when some strobe was high, so between bursts the last Q word stays on the bus. Everything runs on one system clock, with synchronous enables in place of gated clocks. The output follows its input by two register stages.

The stream has no back-pressure. The sources cannot be stalled, so there is no ready input. `out_valid` is a single-cycle qualifier, and the consumer must accept every word it marks. A consumer that needs a steady rate should put a FIFO after this block and load it on `out_valid`.

Top module: `iqm_merge_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, the merger clears `out_data`, `out_valid`, `out_iq` and `collision` to 0 at that edge.
- R2: If a source's strobe is high in cycle c, that source's word appears on `out_data` in cycle c+2, and `out_valid` is high in cycle c+2.
- R3: `out_iq` tags each word by its position in the source's strobe run. It is 0 (I word) in the first strobe cycle and 1 (Q word) in the second, and a third consecutive cycle would count as I again.
- R4: `out_valid` is high in cycle c+2 exactly when at least one strobe is high in cycle c.
- R5: In every cycle where `out_valid` is low, `out_data` keeps the previous cycle's value. The last Q word therefore stays on the bus through the idle gap.
- R6: The data bus of a source whose strobe is low has no effect on `out_data`.
- R7: If several strobes are high in the same cycle, the lowest-numbered source's word is the one that reaches `out_data`.
- R8: `collision` goes to 1 one cycle after any cycle in which two or more strobes are high. It then stays at 1 until reset.
- R9: A stream of three full eight-cycle rotations over sources 0 to 3 gives 24 output words, in order: I then Q for each source, in source order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all registers use its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_vld | input | 4 | Per-source data-valid strobe; bit k belongs to source k |
| src_data | input | 64 | Per-source data words; bits [16k+15:16k] belong to source k |
| out_data | output | 16 | Merged output word, held between bursts |
| out_valid | output | 1 | High for one cycle per merged word |
| out_iq | output | 1 | Word kind while out_valid is high: 0 for I, 1 for Q |
| collision | output | 1 | Sticky flag: two or more strobes were seen in the same cycle |

## Verification
The assertions check the following on every cycle:
- the output is stable while `out_valid` is low;
- `out_valid` never rises without a strobe two cycles earlier;
- a Q-tagged word always directly follows another valid word;
- the priority grant is one-hot and picks the lowest requester;
- the collision flag never drops outside reset.

Only the bench scenarios can show the rest. These are the exact data and tag carried through the two-stage latency, the full eight-cycle rotation order, the immunity to data on idle source buses, and the lowest-index winner's value under collision. The bench checks these against its own cycle model of the strobe pattern.

// File: rtl/iqm_pkg.sv
package iqm_pkg;

  // Kind of word carried on the merged bus.
  typedef enum logic {
    WORD_I = 1'b0,
    WORD_Q = 1'b1
  } iq_kind_e;

  // Number of bits set in a strobe vector (vector width capped at 32).
  function automatic int unsigned strobe_count(input logic [31:0] v, input int unsigned n);
    int unsigned c;
    c = 0;
    for (int unsigned i = 0; i < n; i++) begin
      if (v[i]) c++;
    end
    return c;
  endfunction

endpackage

// File: rtl/iqm_src_latch.sv
// Per-source capture stage: loads only when the source strobe is high and
// tracks the word position inside the current strobe run.
module iqm_src_latch
  import iqm_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] lat_q,
  output iq_kind_e      kind
);

  logic phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (vld) begin
      lat_q <= din;
    end
  end

  // Phase toggles each strobe cycle and returns to I once the strobe drops.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
    end else if (vld) begin
      phase_q <= ~phase_q;
    end else begin
      phase_q <= 1'b0;
    end
  end

  assign kind = phase_q ? WORD_Q : WORD_I;

  // R3: the Q phase is reached only from an I phase with the strobe held high.
  a_r3_phase_from_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q |-> ($past(vld) && !$past(phase_q)));

endmodule

// File: rtl/iqm_prio.sv
// Fixed-priority pick among the strobes, with a sticky collision flag.
module iqm_prio
  import iqm_pkg::*;
#(
  parameter int unsigned N  = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  vld,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic          collision
);

  logic [N-1:0] grant;
  logic         multi;

  // The downward scan leaves the lowest requesting index in idx.
  always_comb begin
    idx   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vld[i]) begin
        idx   = IW'(i);
        grant = N'(1) << i;
      end
    end
  end

  assign any   = |vld;
  assign multi = strobe_count(32'(vld), N) > 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      collision <= 1'b0;
    end else if (multi) begin
      collision <= 1'b1;
    end
  end

  a_r7_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((vld & (grant - N'(1))) == '0) && ((vld & grant) != '0));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    collision |=> collision);

endmodule

// File: rtl/iqm_out_stage.sv
// Selection register and shared output register.
module iqm_out_stage
  import iqm_pkg::*;
#(
  parameter int unsigned N  = 4,
  parameter int unsigned DW = 16,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 any,
  input  logic [IW-1:0]        idx,
  input  logic [N-1:0]         kind_bus,
  input  logic [N-1:0][DW-1:0] lat_bus,
  output logic [DW-1:0]        out_data,
  output logic                 out_valid,
  output logic                 out_iq
);

  logic          any_q;
  logic [IW-1:0] sel_q;
  logic          iq_q;

  // Stage 1: note which latch now holds the winning word, and its kind.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      any_q <= 1'b0;
      sel_q <= '0;
      iq_q  <= 1'b0;
    end else begin
      any_q <= any;
      if (any) begin
        sel_q <= idx;
        iq_q  <= kind_bus[idx];
      end
    end
  end

  // Stage 2: the shared register loads only when some strobe was seen.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      out_iq    <= 1'b0;
    end else begin
      out_valid <= any_q;
      if (any_q) begin
        out_data <= lat_bus[sel_q];
        out_iq   <= iq_q;
      end
    end
  end

  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

endmodule

// File: rtl/iqm_merge_top.sv
module iqm_merge_top
  import iqm_pkg::*;
#(
  parameter int unsigned N  = 4,
  parameter int unsigned DW = 16,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_vld,
  input  logic [N*DW-1:0] src_data,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          out_iq,
  output logic          collision
);

  logic [N-1:0][DW-1:0] lat_bus;
  logic [N-1:0]         kind_bus;
  logic                 any;
  logic [IW-1:0]        idx;

  for (genvar k = 0; k < N; k++) begin : g_src
    iq_kind_e kind_k;
    iqm_src_latch #(.DW(DW)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .vld   (src_vld[k]),
      .din   (src_data[k*DW +: DW]),
      .lat_q (lat_bus[k]),
      .kind  (kind_k)
    );
    assign kind_bus[k] = (kind_k == WORD_Q);
  end

  iqm_prio #(.N(N)) u_prio (
    .clk       (clk),
    .rst_n     (rst_n),
    .vld       (src_vld),
    .any       (any),
    .idx       (idx),
    .collision (collision)
  );

  iqm_out_stage #(.N(N), .DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .any       (any),
    .idx       (idx),
    .kind_bus  (kind_bus),
    .lat_bus   (lat_bus),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_iq    (out_iq)
  );

  // R4: every output word traces back to a strobe two cycles earlier.
  a_r4_valid_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(|src_vld, 2));

  // R3: a Q word on the bus always directly follows another valid word.
  a_r3_q_follows_word: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_iq) |-> $past(out_valid));

endmodule

// File: tb/tb_iqm_merge_top.sv
`timescale 1ns/1ps
module tb_iqm_merge_top;

  localparam int N  = 4;
  localparam int DW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    src_vld = '0;
  logic [N*DW-1:0] src_data = '0;
  logic [DW-1:0]   out_data;
  logic            out_valid;
  logic            out_iq;
  logic            collision;

  always #2.5 clk = ~clk;

  iqm_merge_top #(.N(N), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .src_vld(src_vld), .src_data(src_data),
    .out_data(out_data), .out_valid(out_valid), .out_iq(out_iq), .collision(collision)
  );

  int n_chk = 0;
  int n_bad = 0;
  int ov_cnt = 0;
  bit done = 1'b0;

  // Bench model: p0 holds the most recent drive, p1 the one before.
  logic          p0_v, p1_v;
  logic [DW-1:0] p0_d, p1_d;
  logic          p0_q, p1_q;
  logic [N-1:0]  ph;
  logic [DW-1:0] hold_d;
  logic          coll_exp;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    p0_v = 0; p1_v = 0; p0_d = '0; p1_d = '0; p0_q = 0; p1_q = 0;
    ph = '0; hold_d = '0; coll_exp = 0;
  endtask

  // One cycle: check the outputs due now, then drive the next input.
  task automatic cyc(input logic [N-1:0] v, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                     input logic [DW-1:0] d2, input logic [DW-1:0] d3);
    logic [DW-1:0] dd [N];
    int w;
    @(negedge clk);
    chk(out_valid == p1_v, "R4 out_valid", 32'(out_valid), 32'(p1_v));
    if (p1_v) begin
      ov_cnt++;
      chk(out_data == p1_d, "R2 out_data", 32'(out_data), 32'(p1_d));
      chk(out_iq == p1_q, "R3 out_iq", 32'(out_iq), 32'(p1_q));
      hold_d = p1_d;
    end else begin
      chk(out_data == hold_d, "R5 hold", 32'(out_data), 32'(hold_d));
    end
    chk(collision == coll_exp, "R8 collision", 32'(collision), 32'(coll_exp));
    p1_v = p0_v; p1_d = p0_d; p1_q = p0_q;
    dd[0] = d0; dd[1] = d1; dd[2] = d2; dd[3] = d3;
    w = -1;
    for (int k = N - 1; k >= 0; k--) if (v[k]) w = k;
    p0_v = (w >= 0);
    if (w >= 0) begin
      p0_d = dd[w];
      p0_q = ph[w];
    end
    for (int k = 0; k < N; k++) ph[k] = v[k] ? ~ph[k] : 1'b0;
    if ($countones(v) > 1) coll_exp = 1'b1;
    src_vld = v;
    src_data = {d3, d2, d1, d0};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    src_vld = '0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is held
    chk(out_data == '0, "R1 out_data", 32'(out_data), 0);
    chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 0);
    chk(out_iq == 1'b0, "R1 out_iq", 32'(out_iq), 0);
    chk(collision == 1'b0, "R1 collision", 32'(collision), 0);
    model_clear();
    rst_n = 1'b1;
  endtask

  // R2 and R3: a single source burst, I then Q.
  task automatic t_single();
    cyc(4'b0010, 16'hdead, 16'h1111, 16'hbeef, 16'h0bad);
    cyc(4'b0010, 16'hdead, 16'h2222, 16'hbeef, 16'h0bad);
    cyc(4'b0000, '0, '0, '0, '0);
    chk(out_data == 16'h1111 && out_iq == 1'b0, "R2 first word I", 32'({out_iq, out_data}), 32'h1111);
    cyc(4'b0000, '0, '0, '0, '0);
    chk(out_data == 16'h2222 && out_iq == 1'b1, "R3 second word Q", 32'({out_iq, out_data}), 32'h12222);
    repeat (4) cyc(4'b0000, '0, '0, '0, '0);
  endtask

  // R9 and R5: three full rotations, 8 cycles per source period.
  task automatic t_rotation();
    ov_cnt = 0;
    for (int r = 0; r < 3; r++) begin
      for (int s = 0; s < 8; s++) begin
        logic [N-1:0] v;
        logic [DW-1:0] d [N];
        v = '0;
        for (int k = 0; k < N; k++) d[k] = 16'hf000 + 16'(k * 256 + s);
        v[s / 2] = 1'b1;
        d[s / 2] = 16'((s / 2) * 256 + r * 16 + (s % 2));
        cyc(v, d[0], d[1], d[2], d[3]);
      end
    end
    repeat (4) cyc('0, '0, '0, '0, '0);
    chk(ov_cnt == 24, "R9 word count", 32'(ov_cnt), 24);
    chk(out_data == 16'h0321, "R9 last Q held", 32'(out_data), 32'h0321);
  endtask

  // R6: data on buses of idle sources never reaches the output.
  task automatic t_ignore();
    cyc(4'b0001, 16'h00a0, 16'h5555, 16'h6666, 16'h7777);
    cyc(4'b0001, 16'h00a1, 16'h5556, 16'h6667, 16'h7778);
    for (int i = 0; i < 6; i++)
      cyc(4'b0000, 16'hc000 + 16'(i), 16'hc100 + 16'(i), 16'hc200 + 16'(i), 16'hc300 + 16'(i));
    chk(out_data == 16'h00a1, "R6 idle buses ignored", 32'(out_data), 32'h00a1);
  endtask

  // R7 and R8: overlapping strobes; lowest index wins, flag sticks.
  task automatic t_collision();
    chk(collision == 1'b0, "R8 flag clear before overlap", 32'(collision), 0);
    cyc(4'b0110, '0, 16'h0b10, 16'h0c10, '0);
    cyc(4'b0110, '0, 16'h0b11, 16'h0c11, '0);
    cyc(4'b0000, '0, '0, '0, '0);
    chk(out_data == 16'h0b10, "R7 lowest source wins", 32'(out_data), 32'h0b10);
    chk(collision == 1'b1, "R8 flag set", 32'(collision), 1);
    cyc(4'b1000, '0, '0, '0, 16'h0d00);
    repeat (8) cyc(4'b0000, '0, '0, '0, '0);
    chk(collision == 1'b1, "R8 flag sticky", 32'(collision), 1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_clear();
    do_reset();
    t_single();
    t_rotation();
    t_ignore();
    t_collision();
    do_reset();
    repeat (3) cyc('0, '0, '0, '0, '0);
    t_single();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule